// File: doc/BRIEF.md
# Entropy Stream Byte-Unstuffing Filter

This block sits in the byte path of an entropy-coded image segment, between an input buffer and a Huffman decoder. Bytes arrive one per transfer over a valid/ready handshake. A byte of 0xFF opens a two-byte pair. When 0x00 follows, the pair carries one literal 0xFF data byte. When any other byte follows, the pair is a marker and the whole pair leaves the data path. A run of 0xFF fill bytes leaves the pair open.

Every emitted byte carries a 4-bit context tag. The two header flags are sampled on the transfer that completes the data byte. The end-of-block flag and the end-of-image flag are set on the last data byte before a restart marker or the end-of-image marker. To make that possible, the most recent data byte waits in a one-byte hold register until the filter knows what follows it. If no byte is waiting when such a marker arrives, the filter emits a flush word of 0x00 that carries the flag. An end-of-image marker also raises a one-cycle pulse, which upstream uses to flush its buffer.

Top module: `ecs_unstuff`

## Requirements
- R1: An accepted 0xFF followed by an accepted 0x00 yields exactly one data byte of value 0xFF.
- R2: 0xFF followed by a nonzero byte that is neither 0xFF, nor 0xD9, nor in 0xD0..0xD7 is a marker. Neither of its bytes appears at the output, and the stream on either side of it is unaffected.
- R3: 0xFF followed by 0xFF keeps the pair open, so 0xFF 0xFF 0x00 yields a single 0xFF data byte.
- R4: The pair 0xFF 0xD9 raises `eoi_pulse` for exactly one cycle, in the cycle after the transfer of 0xD9.
- R5: Context bit 3 (end of image) is set on the last data byte accepted before 0xFF 0xD9. If no data byte is held at that point, a flush word of 0x00 with bit 3 set is emitted instead. The same word is on the output in the cycle in which `eoi_pulse` is high.
- R6: A restart pair 0xFF 0xD0..0xD7 is dropped from the data path. It sets context bit 2 (end of block) on the last data byte held before it, or on a flush word of 0x00 if none is held. Bits 2 and 3 are never both set.
- R7: Context bit 0 copies `hdr_valid` and bit 1 copies `hdr_bank`. Both are sampled on the transfer that completes the data byte (for a stuffed pair, the 0x00 byte). A flush word samples them on the transfer that completes the marker.
- R8: A data byte is not emitted until the next data byte or a restart or end-of-image marker has been accepted. Data bytes leave in their arrival order.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_ctx` stay stable and `in_ready` is low.
- R10: Reset clears the output valid flag, the end-of-image pulse, the hold register and any open 0xFF pair. A 0x00 received after reset is a plain data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Filter accepts a byte in this cycle |
| hdr_valid | input | 1 | Header-valid flag copied to context bit 0 |
| hdr_bank | input | 1 | Header bank select copied to context bit 1 |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 8 | Output data byte |
| out_ctx | output | 4 | Context: bit0 header valid, bit1 bank, bit2 end of block, bit3 end of image |
| out_ready | input | 1 | Downstream takes the output word |
| eoi_pulse | output | 1 | One-cycle end-of-image indication |

## Verification
The bench builds the filter with its default parameters: a marker prefix of 0xFF, an end-of-image code of 0xD9, and eight restart codes starting at 0xD0. With these values the literal corner cases can be reached directly: stuffed pairs, fill runs, a restart code at each end of its range, and flush words that follow reset or a previous end of image. Stalling the output port exercises the hold-and-block path.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_DATA = 2'd1,
    EV_EOB  = 2'd2,
    EV_EOI  = 2'd3
  } ecs_event_e;

  localparam int CTX_W = 4;
  localparam int CTX_HV  = 0;
  localparam int CTX_BNK = 1;
  localparam int CTX_EOB = 2;
  localparam int CTX_EOI = 3;
endpackage

// File: rtl/ecs_pair_classify.sv
module ecs_pair_classify
  import ecs_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MARK      = 'hFF,
  parameter int EOI_CODE  = 'hD9,
  parameter int RST_BASE  = 'hD0,
  parameter int RST_COUNT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] byte_in,
  output ecs_event_e    ev,
  output logic [DW-1:0] ev_byte
);
  localparam logic [DW-1:0] MARK_B = DW'(MARK);
  localparam logic [DW-1:0] EOI_B  = DW'(EOI_CODE);
  localparam int            RST_LAST = RST_BASE + RST_COUNT - 1;

  logic pend_q, pend_d;
  logic is_rst;

  assign is_rst = (int'(byte_in) >= RST_BASE) && (int'(byte_in) <= RST_LAST);

  always_comb begin
    pend_d  = pend_q;
    ev      = EV_NONE;
    ev_byte = byte_in;
    if (accept) begin
      if (!pend_q) begin
        if (byte_in == MARK_B) pend_d = 1'b1;
        else                   ev = EV_DATA;
      end else begin
        if (byte_in == '0) begin
          ev      = EV_DATA;
          ev_byte = MARK_B;
          pend_d  = 1'b0;
        end else if (byte_in == MARK_B) begin
          pend_d = 1'b1;
        end else begin
          pend_d = 1'b0;
          if (byte_in == EOI_B) ev = EV_EOI;
          else if (is_rst)      ev = EV_EOB;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (accept) pend_q <= pend_d;
  end

  // R3: a fill byte keeps the pair open
  p_fill_keeps_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && pend_q && byte_in == MARK_B |=> pend_q);
  // R1: a stuffed pair closes the pair
  p_stuff_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && pend_q && byte_in == '0 |=> !pend_q);
endmodule

// File: rtl/ecs_hold_out.sv
module ecs_hold_out
  import ecs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  ecs_event_e       ev,
  input  logic [DW-1:0]    ev_byte,
  input  logic [1:0]       hdr_bits,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic [CTX_W-1:0] out_ctx,
  output logic             slot_free
);
  logic             hold_vld_q, hold_vld_d;
  logic [DW-1:0]    hold_data_q, hold_data_d;
  logic [1:0]       hold_hdr_q, hold_hdr_d;
  logic             ov_q, ov_d;
  logic [DW-1:0]    od_q, od_d;
  logic [CTX_W-1:0] oc_q, oc_d;
  logic             push;
  logic [DW-1:0]    push_data;
  logic [CTX_W-1:0] push_ctx;

  assign slot_free = !ov_q || out_ready;

  always_comb begin
    hold_vld_d  = hold_vld_q;
    hold_data_d = hold_data_q;
    hold_hdr_d  = hold_hdr_q;
    push        = 1'b0;
    push_data   = hold_data_q;
    push_ctx    = {2'b00, hold_hdr_q};
    if (accept) begin
      unique case (ev)
        EV_DATA: begin
          push        = hold_vld_q;
          hold_vld_d  = 1'b1;
          hold_data_d = ev_byte;
          hold_hdr_d  = hdr_bits;
        end
        EV_EOB, EV_EOI: begin
          push       = 1'b1;
          hold_vld_d = 1'b0;
          if (!hold_vld_q) begin
            push_data = '0;
            push_ctx  = {2'b00, hdr_bits};
          end
          if (ev == EV_EOI) push_ctx[CTX_EOI] = 1'b1;
          else              push_ctx[CTX_EOB] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ov_d = ov_q;
    od_d = od_q;
    oc_d = oc_q;
    if (push) begin
      ov_d = 1'b1;
      od_d = push_data;
      oc_d = push_ctx;
    end else if (out_ready) begin
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q  <= 1'b0;
      hold_data_q <= '0;
      hold_hdr_q  <= '0;
      ov_q        <= 1'b0;
      od_q        <= '0;
      oc_q        <= '0;
    end else begin
      if (accept) begin
        hold_vld_q  <= hold_vld_d;
        hold_data_q <= hold_data_d;
        hold_hdr_q  <= hold_hdr_d;
      end
      ov_q <= ov_d;
      od_q <= od_d;
      oc_q <= oc_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_ctx   = oc_q;

  // R9: a stalled word stays put
  p_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ctx));
  // R6: the two boundary flags never appear together
  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_ctx[CTX_EOB] && out_ctx[CTX_EOI]));
endmodule

// File: rtl/ecs_unstuff.sv
module ecs_unstuff
  import ecs_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MARK      = 'hFF,
  parameter int EOI_CODE  = 'hD9,
  parameter int RST_BASE  = 'hD0,
  parameter int RST_COUNT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic             in_ready,
  input  logic             hdr_valid,
  input  logic             hdr_bank,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic [CTX_W-1:0] out_ctx,
  input  logic             out_ready,
  output logic             eoi_pulse
);
  ecs_event_e    ev;
  logic [DW-1:0] ev_byte;
  logic          accept;
  logic          slot_free;
  logic          eoi_q, eoi_d;

  assign in_ready = slot_free;
  assign accept   = in_valid && slot_free;

  ecs_pair_classify #(
    .DW(DW), .MARK(MARK), .EOI_CODE(EOI_CODE),
    .RST_BASE(RST_BASE), .RST_COUNT(RST_COUNT)
  ) u_classify (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .byte_in (in_data),
    .ev      (ev),
    .ev_byte (ev_byte)
  );

  ecs_hold_out #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .ev        (ev),
    .ev_byte   (ev_byte),
    .hdr_bits  ({hdr_bank, hdr_valid}),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ctx   (out_ctx),
    .slot_free (slot_free)
  );

  assign eoi_d = accept && (ev == EV_EOI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eoi_q <= 1'b0;
    else        eoi_q <= eoi_d;
  end

  assign eoi_pulse = eoi_q;

  // R4: the pulse lasts one cycle
  p_eoi_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |=> !eoi_pulse);
  // R5: the flagged word is presented together with the pulse
  p_eoi_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> out_valid && out_ctx[CTX_EOI]);
  // R9: a stalled output blocks the input
  p_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/ecs_unstuff_tb.sv
module ecs_unstuff_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       hdr_valid;
  logic       hdr_bank;
  logic       out_valid;
  logic [7:0] out_data;
  logic [3:0] out_ctx;
  logic       out_ready;
  logic       eoi_pulse;

  int checks = 0;
  int errors = 0;
  int eoi_cnt = 0;
  int cyc = 0;
  logic [11:0] got_q[$];
  logic [11:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ecs_unstuff dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .hdr_valid(hdr_valid), .hdr_bank(hdr_bank),
    .out_valid(out_valid), .out_data(out_data), .out_ctx(out_ctx),
    .out_ready(out_ready), .eoi_pulse(eoi_pulse)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) got_q.push_back({out_ctx, out_data});
      if (eoi_pulse) eoi_cnt++;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    got_q.delete();
    exp_q.delete();
    eoi_cnt = 0;
  endtask

  task automatic send(logic [7:0] b);
    in_valid = 1'b1;
    in_data = b;
    #1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_w(logic [3:0] c, logic [7:0] d);
    exp_q.push_back({c, d});
  endtask

  task automatic compare(string req, int eois);
    repeat (4) @(negedge clk);
    chk({req, " word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(req, int'(got_q[i]), int'(exp_q[i]));
    chk("R4 eoi pulses", eoi_cnt, eois);
    got_q.delete();
    exp_q.delete();
    eoi_cnt = 0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    #3;
    chk("R10 out_valid in reset", int'(out_valid), 0);
    chk("R10 eoi in reset", int'(eoi_pulse), 0);
    do_reset();
    chk("R10 in_ready after reset", int'(in_ready), 1);
    send(8'hFF);
    do_reset();
    send(8'h00); send(8'hFF); send(8'hD9);
    expect_w(4'h9, 8'h00);
    compare("R10 pair cleared by reset", 1);
  endtask

  task automatic t_plain();
    send(8'h11);
    chk("R8 first byte held", got_q.size(), 0);
    repeat (2) @(negedge clk);
    chk("R8 still held", int'(out_valid), 0);
    send(8'h22); send(8'h33); send(8'hFF); send(8'hD9);
    expect_w(4'h1, 8'h11); expect_w(4'h1, 8'h22); expect_w(4'h9, 8'h33);
    compare("R5 eoi flag on last byte", 1);
  endtask

  task automatic t_stuff();
    send(8'h12); send(8'hFF); send(8'h00); send(8'h34);
    send(8'hFF); send(8'hD9);
    expect_w(4'h1, 8'h12); expect_w(4'h1, 8'hFF); expect_w(4'h9, 8'h34);
    compare("R1 stuffed pair", 1);
  endtask

  task automatic t_marker_fill();
    send(8'h55); send(8'hFF); send(8'hC4); send(8'h66);
    send(8'hFF); send(8'hFF); send(8'hFF); send(8'h00);
    send(8'hFF); send(8'hD8); send(8'hFF); send(8'hDA);
    send(8'hFF); send(8'hD9);
    expect_w(4'h1, 8'h55); expect_w(4'h1, 8'h66); expect_w(4'h9, 8'hFF);
    compare("R2 R3 marker dropped and fill run", 1);
  endtask

  task automatic t_restart();
    send(8'h01); send(8'h02); send(8'hFF); send(8'hD0);
    send(8'h03); send(8'hFF); send(8'hD7);
    send(8'h04); send(8'hFF); send(8'hD9);
    expect_w(4'h1, 8'h01); expect_w(4'h5, 8'h02);
    expect_w(4'h5, 8'h03); expect_w(4'h9, 8'h04);
    compare("R6 restart flags", 1);
  endtask

  task automatic t_flush();
    send(8'hFF); send(8'hD3);
    send(8'hFF); send(8'hD9);
    send(8'hFF); send(8'hD9);
    expect_w(4'h5, 8'h00); expect_w(4'h9, 8'h00); expect_w(4'h9, 8'h00);
    compare("R5 R6 flush words", 2);
  endtask

  task automatic t_header_bits();
    hdr_valid = 1'b1; hdr_bank = 1'b0;
    send(8'hA1);
    hdr_valid = 1'b0; hdr_bank = 1'b1;
    send(8'hFF);
    hdr_valid = 1'b1; hdr_bank = 1'b1;
    send(8'h00);
    hdr_valid = 1'b0; hdr_bank = 1'b0;
    send(8'hFF);
    hdr_valid = 1'b0; hdr_bank = 1'b1;
    send(8'hD9);
    send(8'hFF);
    send(8'hD9);
    expect_w(4'h1, 8'hA1); expect_w(4'hB, 8'hFF); expect_w(4'hA, 8'h00);
    compare("R7 header bits sampled", 2);
    hdr_valid = 1'b1; hdr_bank = 1'b0;
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    send(8'h0A); send(8'h0B);
    in_valid = 1'b1; in_data = 8'h0C;
    #1;
    for (int i = 0; i < 3; i++) begin
      chk("R9 in_ready low while stalled", int'(in_ready), 0);
      chk("R9 stalled data stable", int'(out_data), 8'h0A);
      chk("R9 stalled valid", int'(out_valid), 1);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    send(8'hFF); send(8'hD9);
    expect_w(4'h1, 8'h0A); expect_w(4'h1, 8'h0B); expect_w(4'h9, 8'h0C);
    compare("R9 order after stall", 1);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    hdr_valid = 1'b1;
    hdr_bank = 1'b0;
    out_ready = 1'b1;
    t_reset_state();
    t_plain();
    t_stuff();
    t_marker_fill();
    t_restart();
    t_flush();
    t_header_bits();
    t_backpressure();
    finish_run();
  end
endmodule